// File: doc/BRIEF.md
# 32-bit Integer ALU with Two-Level Carry Lookahead

This block is the arithmetic and logic unit of a simple RISC integer datapath. It takes two 32-bit operands and a 4-bit operation code and returns a 32-bit result with a carry flag and an overflow flag. It supports add and subtract in signed and unsigned forms, the four bitwise operations AND, OR, XOR and NOR, and signed and unsigned set-less-than. The unit is purely combinational. An integrating datapath may place registers in front of it or behind it.

All arithmetic, including both comparisons, goes through one adder. Subtraction feeds the inverted second operand into the adder and forces the carry-in high. The adder does not use a ripple chain. Four-bit lookahead groups produce group generate and group propagate terms. A second lookahead unit combines four groups into a 16-bit section, and one more lookahead unit joins the sections.

Top module: `alu32_core`

## Requirements
- R1: Mode 0000 (signed add) and mode 0001 (unsigned add) return S = A + B modulo 2^32. carry_o is the carry out of bit 31.
- R2: Mode 0010 (signed subtract) and mode 0011 (unsigned subtract) return S = A + ~B + 1 modulo 2^32. carry_o is the carry out of that sum, so it is 1 exactly when A >= B unsigned.
- R3: In modes 0000 and 0010, ovf_o equals the carry into bit 31 XOR the carry out of bit 31. For example, 0x7FFFFFFF + 1 and 0x80000000 - 1 both set ovf_o.
- R4: Modes 0001 and 0011 never assert ovf_o, even when the signed result would wrap. carry_o is still reported in these modes.
- R5: The logic modes are 0100 AND, 0101 OR, 0110 XOR and 0111 NOR. Each is applied bit by bit, and carry_o = ovf_o = 0 in all four.
- R6: Mode 1010 (signed set-less-than) returns 1 in bit 0 when A < B as two's-complement numbers. The flag is taken as the sign of A - B XOR the overflow of that subtraction. Bits 31..1 are 0 and both flags are 0.
- R7: Mode 1011 (unsigned set-less-than) returns 1 in bit 0 exactly when A - B produces no carry out, which means A < B unsigned. Bits 31..1 are 0 and both flags are 0.
- R8: The unused codes 1000, 1001 and 1100 through 1111 return S = 0 with both flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| mode_i | input | 4 | Operation code |
| s_o | output | 32 | Result |
| carry_o | output | 1 | Carry out of the adder (arithmetic modes only) |
| ovf_o | output | 1 | Signed overflow (signed add and subtract only) |

## Verification
A table of directed vectors covers several cases:
- The two signed wrap points, run in both the signed and the unsigned form of each operation. These show whether overflow is gated by signedness.
- Equal operands and operands of opposite sign in both comparisons. Signed and unsigned order disagree here, and the signed flag depends on the overflow correction.
- A carry that has to cross the boundary between the two 16-bit sections, which exposes a broken second lookahead level.
- Complementary bit patterns for the four logic operations, chosen so that each operation gives a different result.
- Unused codes with all-ones operands.

Random operands and random codes, some of them mixed with corner values, are then compared against a reference model written in plain arithmetic.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    MODE_ADD  = 4'b0000,
    MODE_ADDU = 4'b0001,
    MODE_SUB  = 4'b0010,
    MODE_SUBU = 4'b0011,
    MODE_AND  = 4'b0100,
    MODE_OR   = 4'b0101,
    MODE_XOR  = 4'b0110,
    MODE_NOR  = 4'b0111,
    MODE_SLT  = 4'b1010,
    MODE_SLTU = 4'b1011
  } alu_mode_e;

  // bits per first-level lookahead group, groups per second-level section
  localparam int unsigned CLA_W   = 4;
  localparam int unsigned CLA_GPS = 4;

endpackage

// File: rtl/alu_cla_unit.sv
// Flattened lookahead over N positions: carry into each position plus block generate/propagate.
module alu_cla_unit #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  input  logic         c_i,
  output logic [N-1:0] c_o,
  output logic         g_o,
  output logic         p_o
);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic acc;
      acc = c_i;
      for (int k = 0; k < i; k++) acc = acc & p_i[k];
      for (int j = 0; j < i; j++) begin
        logic term;
        term = g_i[j];
        for (int k = j + 1; k < i; k++) term = term & p_i[k];
        acc = acc | term;
      end
      c_o[i] = acc;
    end
  end

  always_comb begin
    g_o = 1'b0;
    for (int j = 0; j < N; j++) begin
      logic term;
      term = g_i[j];
      for (int k = j + 1; k < N; k++) term = term & p_i[k];
      g_o = g_o | term;
    end
    p_o = &p_i;
  end

endmodule

// File: rtl/alu_cla_adder.sv
module alu_cla_adder
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_msb_o,
  output logic             c_out_o
);

  localparam int unsigned SEC_W = CLA_W * CLA_GPS;
  localparam int unsigned NSEC  = WIDTH / SEC_W;
  localparam int unsigned NGRP  = NSEC * CLA_GPS;

  logic [WIDTH-1:0] g, p, c;
  logic [NGRP-1:0]  grp_g, grp_p, grp_c;
  logic [NSEC-1:0]  sec_g, sec_p, sec_c;
  logic             top_g, top_p;

  assign g = a_i & b_i;
  assign p = a_i ^ b_i;

  alu_cla_unit #(.N(NSEC)) u_top (
    .g_i(sec_g), .p_i(sec_p), .c_i(c_i),
    .c_o(sec_c), .g_o(top_g), .p_o(top_p)
  );

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    alu_cla_unit #(.N(CLA_GPS)) u_lvl2 (
      .g_i(grp_g[s*CLA_GPS +: CLA_GPS]), .p_i(grp_p[s*CLA_GPS +: CLA_GPS]),
      .c_i(sec_c[s]), .c_o(grp_c[s*CLA_GPS +: CLA_GPS]),
      .g_o(sec_g[s]), .p_o(sec_p[s])
    );
    for (genvar k = 0; k < CLA_GPS; k++) begin : g_grp
      localparam int unsigned IDX = s * CLA_GPS + k;
      alu_cla_unit #(.N(CLA_W)) u_lvl1 (
        .g_i(g[IDX*CLA_W +: CLA_W]), .p_i(p[IDX*CLA_W +: CLA_W]),
        .c_i(grp_c[IDX]), .c_o(c[IDX*CLA_W +: CLA_W]),
        .g_o(grp_g[IDX]), .p_o(grp_p[IDX])
      );
    end
  end

  assign sum_o   = p ^ c;
  assign c_msb_o = c[WIDTH-1];
  assign c_out_o = top_g | (top_p & c_i);

  // R1, R2: lookahead tree agrees with a plain wide sum
  always_comb begin
    a_r1_cla_sum: assert ({c_out_o, sum_o} ==
                          ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i}))
      else $error("lookahead sum mismatch");
  end

endmodule

// File: rtl/alu32_core.sv
module alu32_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       mode_i,
  output logic [WIDTH-1:0] s_o,
  output logic             carry_o,
  output logic             ovf_o
);

  logic             is_sub;
  logic [WIDTH-1:0] b_eff, sum;
  logic             c_msb, c_out, ovf_raw, lt_s, lt_u;

  assign is_sub = (mode_i == MODE_SUB) || (mode_i == MODE_SUBU) ||
                  (mode_i == MODE_SLT) || (mode_i == MODE_SLTU);
  assign b_eff  = is_sub ? ~b_i : b_i;

  alu_cla_adder #(.WIDTH(WIDTH)) u_add (
    .a_i(a_i), .b_i(b_eff), .c_i(is_sub),
    .sum_o(sum), .c_msb_o(c_msb), .c_out_o(c_out)
  );

  assign ovf_raw = c_msb ^ c_out;
  assign lt_s    = sum[WIDTH-1] ^ ovf_raw;  // sign corrected for wrap
  assign lt_u    = ~c_out;                  // borrow

  always_comb begin
    s_o     = '0;
    carry_o = 1'b0;
    ovf_o   = 1'b0;
    case (mode_i)
      MODE_ADD, MODE_SUB: begin
        s_o = sum; carry_o = c_out; ovf_o = ovf_raw;
      end
      MODE_ADDU, MODE_SUBU: begin
        s_o = sum; carry_o = c_out;
      end
      MODE_AND:  s_o = a_i & b_i;
      MODE_OR:   s_o = a_i | b_i;
      MODE_XOR:  s_o = a_i ^ b_i;
      MODE_NOR:  s_o = ~(a_i | b_i);
      MODE_SLT:  s_o = {{(WIDTH-1){1'b0}}, lt_s};
      MODE_SLTU: s_o = {{(WIDTH-1){1'b0}}, lt_u};
      default: ;
    endcase
  end

  always_comb begin
    if (mode_i == MODE_ADD)
      a_r3_add_ovf_sign: assert (ovf_o == ((a_i[WIDTH-1] == b_i[WIDTH-1]) &&
                                           (s_o[WIDTH-1] != a_i[WIDTH-1])))
        else $error("signed add overflow wrong");
    if (mode_i == MODE_SUB)
      a_r2_sub_value: assert (s_o == a_i - b_i)
        else $error("subtract result wrong");
    if ((mode_i == MODE_ADDU) || (mode_i == MODE_SUBU))
      a_r4_unsigned_no_ovf: assert (!ovf_o)
        else $error("unsigned mode raised overflow");
    if ((mode_i == MODE_AND) || (mode_i == MODE_OR) ||
        (mode_i == MODE_XOR) || (mode_i == MODE_NOR))
      a_r5_logic_flags: assert (!carry_o && !ovf_o)
        else $error("logic mode raised a flag");
    if (mode_i == MODE_SLT)
      a_r6_slt_signed: assert ((s_o == {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))}) &&
                               !carry_o && !ovf_o)
        else $error("signed compare wrong");
    if (mode_i == MODE_SLTU)
      a_r7_slt_unsigned: assert ((s_o == {{(WIDTH-1){1'b0}}, (a_i < b_i)}) &&
                                 !carry_o && !ovf_o)
        else $error("unsigned compare wrong");
    if ((mode_i == 4'b1000) || (mode_i == 4'b1001) || (mode_i[3:2] == 2'b11))
      a_r8_unused_zero: assert ((s_o == '0) && !carry_o && !ovf_o)
        else $error("unused code produced output");
  end

endmodule

// File: tb/sim_alu32_core.sv
`timescale 1ns/1ps
module sim_alu32_core;

  logic        clk = 1'b0;
  logic [31:0] a, b, s;
  logic [3:0]  mode;
  logic        carry, ovf;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  alu32_core u0 (.a_i(a), .b_i(b), .mode_i(mode), .s_o(s), .carry_o(carry), .ovf_o(ovf));

  // {mode, a, b, s, carry, ovf}
  localparam int NV = 21;
  localparam logic [101:0] VEC [NV] = '{
    {4'h0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1},
    {4'h1, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b0},
    {4'h0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0},
    {4'h1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 1'b1, 1'b0},
    {4'h0, 32'h0000FFFF, 32'h00000001, 32'h00010000, 1'b0, 1'b0},
    {4'h2, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 1'b1},
    {4'h3, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 1'b0},
    {4'h2, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0},
    {4'h3, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 1'b0, 1'b0},
    {4'h4, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 1'b0},
    {4'h5, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0, 1'b0, 1'b0},
    {4'h6, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0, 1'b0, 1'b0},
    {4'h7, 32'hF0F0F0F0, 32'hFF00FF00, 32'h000F000F, 1'b0, 1'b0},
    {4'hA, 32'h80000000, 32'h00000001, 32'h00000001, 1'b0, 1'b0},
    {4'hB, 32'h80000000, 32'h00000001, 32'h00000000, 1'b0, 1'b0},
    {4'hA, 32'h00000005, 32'h00000005, 32'h00000000, 1'b0, 1'b0},
    {4'hB, 32'h00000001, 32'h80000000, 32'h00000001, 1'b0, 1'b0},
    {4'hA, 32'h00000001, 32'h80000000, 32'h00000000, 1'b0, 1'b0},
    {4'hA, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0, 1'b0},
    {4'h8, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b0},
    {4'hF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b0}
  };

  function automatic string tag_of(logic [3:0] m);
    case (m)
      4'h0: return "R1 R3";
      4'h1: return "R1 R4";
      4'h2: return "R2 R3";
      4'h3: return "R2 R4";
      4'h4, 4'h5, 4'h6, 4'h7: return "R5";
      4'hA: return "R6";
      4'hB: return "R7";
      default: return "R8";
    endcase
  endfunction

  // reference: {s, carry, ovf}
  function automatic logic [33:0] ref_alu(logic [3:0] m, logic [31:0] x, logic [31:0] y);
    logic [32:0] t;
    logic [31:0] r;
    case (m)
      4'h0, 4'h1: begin
        t = {1'b0, x} + {1'b0, y};
        r = t[31:0];
        return {r, t[32], (m == 4'h0) && (x[31] == y[31]) && (r[31] != x[31])};
      end
      4'h2, 4'h3: begin
        t = {1'b0, x} + {1'b0, ~y} + 33'd1;
        r = t[31:0];
        return {r, t[32], (m == 4'h2) && (x[31] != y[31]) && (r[31] != x[31])};
      end
      4'h4: return {x & y, 2'b00};
      4'h5: return {x | y, 2'b00};
      4'h6: return {x ^ y, 2'b00};
      4'h7: return {~(x | y), 2'b00};
      4'hA: return {31'd0, $signed(x) < $signed(y), 2'b00};
      4'hB: return {31'd0, x < y, 2'b00};
      default: return 34'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] m, input logic [31:0] x,
                       input logic [31:0] y, input logic [33:0] exp);
    mode = m; a = x; b = y;
    #5;
    checks++;
    if ({s, carry, ovf} !== exp) begin
      fails++;
      $display("FAIL %s mode=%h a=%h b=%h: got s=%h c=%b v=%b, expected s=%h c=%b v=%b",
               tag, m, x, y, s, carry, ovf, exp[33:2], exp[1], exp[0]);
    end
  endtask

  function automatic logic [31:0] pick(int sel);
    case (sel)
      0: return 32'h80000000;
      1: return 32'h7FFFFFFF;
      2: return 32'hFFFFFFFF;
      3: return 32'h00000000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    mode = 4'h0; a = '0; b = '0;
    #3;
    // quiescent state with zero inputs (R1)
    check("R1", 4'h0, 32'h0, 32'h0, 34'd0);

    for (int i = 0; i < NV; i++)
      check(tag_of(VEC[i][101:98]), VEC[i][101:98], VEC[i][97:66], VEC[i][65:34], VEC[i][33:0]);

    // remaining unused codes (R8)
    check("R8", 4'h9, 32'h12345678, 32'h9ABCDEF0, 34'd0);
    check("R8", 4'hC, 32'hFFFFFFFF, 32'h00000001, 34'd0);
    check("R8", 4'hD, 32'h80000000, 32'h80000000, 34'd0);
    check("R8", 4'hE, 32'h7FFFFFFF, 32'hFFFFFFFF, 34'd0);

    // equal operands and both wrap points across every code
    for (int m = 0; m < 16; m++) begin
      check(tag_of(4'(m)), 4'(m), 32'hDEADBEEF, 32'hDEADBEEF, ref_alu(4'(m), 32'hDEADBEEF, 32'hDEADBEEF));
      check(tag_of(4'(m)), 4'(m), 32'h7FFFFFFF, 32'h00000001, ref_alu(4'(m), 32'h7FFFFFFF, 32'h00000001));
      check(tag_of(4'(m)), 4'(m), 32'h80000000, 32'h00000001, ref_alu(4'(m), 32'h80000000, 32'h00000001));
    end

    // random operands, some mixed with corner values
    for (int i = 0; i < 2000; i++) begin
      logic [3:0]  m;
      logic [31:0] x, y;
      m = 4'($urandom_range(0, 15));
      x = pick($urandom_range(0, 7));
      y = pick($urandom_range(0, 7));
      check(tag_of(m), m, x, y, ref_alu(m, x, y));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule